// File: doc/BRIEF.md
# I2C Target Byte Engine with Clock-Stretch Wait

This block is the bit-level heart of an I2C target port. For each transfer it moves one byte across the bus, either driving it onto SDA or collecting it from SDA, followed by a ninth acknowledge clock. Both bus lines are open-drain: the block never drives a line high. It only asserts a pull-low request for SCL and for SDA and reads back the resolved level of each line. The start and stop conditions reach it as one-cycle strobes from a separate detector. Address matching is done elsewhere.

Once the acknowledge clock of a byte ends, the engine stretches the clock. It pulls SCL low, pulses an interrupt, and holds the bus until software writes a release bit. While the bus is held, software can read the received byte, load the next byte to send, and change the direction or the acknowledge answer. When sending, the engine also records the level it actually sees on SDA for each bit. A mismatch on a bit it left released sets an error flag, which is how a lost bus is detected.

Software reaches the engine through a small register port: a write strobe with an address and data, and a combinational read with its own address. SCL is taken as already synchronized to the system clock.

Top module: `tgtByteEngine`

## Requirements
- R1: In transmit mode (mode register, address 3, bit 0 = 1) the transmit byte (address 0) goes out most significant bit first. A 0 bit pulls SDA low, a 1 bit leaves it released, and SDA is released during the acknowledge clock.
- R2: On each SCL rising edge of the eight data clocks, the resolved SDA level is shifted into the receive register (address 1), in transmit mode as well as receive mode.
- R3: The SDA level sampled on the rising edge of the ninth clock is stored in status register (address 2) bit 0.
- R4: The falling SCL edge that closes the ninth clock puts the engine into a wait state. In that state it pulls SCL low and keeps it low until released.
- R5: Entering the wait state produces exactly one single-cycle pulse on the interrupt output.
- R6: Writing control (address 4) with bit 0 = 1 during the wait state releases SCL and starts the next byte. Control always reads as 0, and a release write outside the wait state has no effect.
- R7: The next byte uses the transmit byte and mode values that are present at the moment of release, including values changed during the wait.
- R8: Status bit 1 (transmit error) sets when a transmit data bit of 1 is sampled as 0 on SDA. It clears when status is written with bit 1 = 1 or when a start strobe arrives. If a set and a software clear occur in the same cycle, the set wins.
- R9: In receive mode (mode bit 0 = 0) SDA stays released for the eight data clocks. In the ninth clock SDA is pulled low when mode bit 1 = 0 (ACK) and left released when it is 1 (NACK).
- R10: The SDA pull-low request changes only while SCL is low.
- R11: A stop strobe returns the engine to idle, releases SCL and SDA, and ends any wait state without an interrupt.
- R12: After reset both lines are released, the interrupt is low, and the transmit, receive, status and mode registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Resolved SCL level, synchronized |
| sdaIn | input | 1 | Resolved SDA level |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |
| startStb | input | 1 | One-cycle start-condition strobe |
| stopStb | input | 1 | One-cycle stop-condition strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| irq | output | 1 | Wait-state interrupt pulse |

## Verification
Two events can land in the same cycle: the transmit error flag being set by a mismatched sample, and software clearing that flag with a write of 1. The bench raises SCL on a data bit where the engine sends 1 and the bus master forces 0. In that same clock cycle it issues the status write that clears bit 1. The byte is judged correct if the flag reads 1 afterwards, because the hardware set takes priority over the clear.

// File: rtl/tgtBytePkg.sv
package tgtBytePkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SHIFT,
    ST_WAIT
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleData;
    logic sampleAck;
    logic inData;
    logic inAck;
    logic newStart;
    logic stopSeen;
  } engStrobe_t;

  localparam int REG_TX   = 0;
  localparam int REG_RX   = 1;
  localparam int REG_STAT = 2;
  localparam int REG_MODE = 3;
  localparam int REG_CTRL = 4;

endpackage

// File: rtl/tgtByteCtrl.sv
module tgtByteCtrl
  import tgtBytePkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       startStb,
  input  logic       stopStb,
  input  logic       releaseReq,
  output engStrobe_t strb,
  output logic       sclDriveLow,
  output logic       irq
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_W);

  engState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic             sclQ;
  logic             sclRise;
  logic             sclFall;
  logic             busEvent;

  assign sclRise  = sclIn & ~sclQ;
  assign sclFall  = ~sclIn & sclQ;
  assign busEvent = startStb | stopStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sclQ   <= 1'b1;
      irq    <= 1'b0;
    end else begin
      sclQ <= sclIn;
      irq  <= 1'b0;
      if (stopStb) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
      end else if (startStb) begin
        state  <= ST_ARMED;
        bitCnt <= '0;
      end else begin
        unique case (state)
          ST_ARMED: if (sclFall) begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
          end
          ST_SHIFT: if (sclFall) begin
            if (bitCnt == ACK_CNT) begin
              state  <= ST_WAIT;
              bitCnt <= '0;
              irq    <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_WAIT: if (releaseReq) state <= ST_SHIFT;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.loadTx     = !busEvent && ((state == ST_ARMED && sclFall) ||
                                    (state == ST_WAIT && releaseReq));
    strb.shiftTx    = !busEvent && state == ST_SHIFT && sclFall && bitCnt < ACK_CNT;
    strb.sampleData = !busEvent && state == ST_SHIFT && sclRise && bitCnt < ACK_CNT;
    strb.sampleAck  = !busEvent && state == ST_SHIFT && sclRise && bitCnt == ACK_CNT;
    strb.inData     = state == ST_SHIFT && bitCnt < ACK_CNT;
    strb.inAck      = state == ST_SHIFT && bitCnt == ACK_CNT;
    strb.newStart   = startStb && !stopStb;
    strb.stopSeen   = stopStb;
  end

  assign sclDriveLow = (state == ST_WAIT);

  // R5: an interrupt pulse only accompanies the wait state
  a_r5_irq_in_wait: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> sclDriveLow);

  // R4: SCL stays held until a release, stop or start
  a_r4_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow && !releaseReq && !stopStb && !startStb |=> sclDriveLow);

  // R4: stretching begins only after a falling SCL edge
  a_r4_enter_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> !$past(sclIn) && $past(sclQ));

  // R11: stop ends the wait silently
  a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopStb |=> !sclDriveLow && !irq);

endmodule

// File: rtl/tgtByteData.sv
module tgtByteData
  import tgtBytePkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strb,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              sdaDriveLow,
  output logic              releaseReq
);

  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(REG_TX);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(REG_RX);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(REG_MODE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam int MSB = BYTE_W - 1;

  logic [BYTE_W-1:0] txData;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic              modeXmit;
  logic              modeNack;
  logic              ackBit;
  logic              txErr;
  logic              errSet;
  logic              errClr;

  assign releaseReq = wrEn && wrAddr == A_CTRL && wrData[0];
  assign errSet     = strb.sampleData && modeXmit && txShift[MSB] && !sdaIn;
  assign errClr     = (wrEn && wrAddr == A_STAT && wrData[1]) || strb.newStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData   <= '0;
      txShift  <= '1;
      rxShift  <= '0;
      modeXmit <= 1'b0;
      modeNack <= 1'b0;
      ackBit   <= 1'b0;
      txErr    <= 1'b0;
    end else begin
      if (wrEn && wrAddr == A_TX) txData <= wrData;
      if (wrEn && wrAddr == A_MODE) begin
        modeXmit <= wrData[0];
        modeNack <= wrData[1];
      end
      if (strb.loadTx)       txShift <= txData;
      else if (strb.shiftTx) txShift <= {txShift[MSB-1:0], 1'b1};
      if (strb.sampleData)   rxShift <= {rxShift[MSB-1:0], sdaIn};
      if (strb.sampleAck)    ackBit  <= sdaIn;
      if (errSet)            txErr   <= 1'b1;
      else if (errClr)       txErr   <= 1'b0;
    end
  end

  assign sdaDriveLow = (strb.inData && modeXmit && !txShift[MSB]) ||
                       (strb.inAck && !modeXmit && !modeNack);

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      A_TX:   rdData = txData;
      A_RX:   rdData = rxShift;
      A_STAT: begin
        rdData[1] = txErr;
        rdData[0] = ackBit;
      end
      A_MODE: begin
        rdData[1] = modeNack;
        rdData[0] = modeXmit;
      end
      default: rdData = '0;
    endcase
  end

  // R10: no SDA change while SCL stays high
  a_r10_sda_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    sclIn && $past(sclIn) && !$past(strb.newStart) && !$past(strb.stopSeen)
      && !$past(wrEn) |-> $stable(sdaDriveLow));

  // R8: a released bit read back as 0 raises the error
  a_r8_err_sets: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleData && modeXmit && txShift[MSB] && !sdaIn |=> txErr);

  // R3: the ninth-clock sample lands in the status register
  a_r3_ack_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleAck |=> ackBit == $past(sdaIn));

endmodule

// File: rtl/tgtByteEngine.sv
module tgtByteEngine
  import tgtBytePkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              irq
);

  engStrobe_t strb;
  logic       releaseReq;

  tgtByteCtrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .startStb    (startStb),
    .stopStb     (stopStb),
    .releaseReq  (releaseReq),
    .strb        (strb),
    .sclDriveLow (sclDriveLow),
    .irq         (irq)
  );

  tgtByteData #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .sdaDriveLow (sdaDriveLow),
    .releaseReq  (releaseReq)
  );

endmodule

// File: tb/sim_tgtByteEngine.sv
module sim_tgtByteEngine;

  typedef struct packed {
    logic       xmit;
    logic       nack;
    logic       mAck;
    logic [7:0] txb;
    logic [7:0] mb;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 8'hA5, 8'hFF},
    '{1'b1, 1'b0, 1'b1, 8'h3C, 8'hFF},
    '{1'b1, 1'b0, 1'b0, 8'hF0, 8'hEF},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h5A},
    '{1'b0, 1'b1, 1'b1, 8'h00, 8'hC3},
    '{1'b1, 1'b0, 1'b0, 8'h0F, 8'hF7},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h81}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sclBus, sdaBus;
  logic       sclDriveLow, sdaDriveLow;
  logic       startStb = 1'b0;
  logic       stopStb = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int irqCount = 0;
  int sdaHighViol = 0;
  logic prevScl = 1'b1;
  logic prevDrv = 1'b0;

  always #2.5 clk = ~clk;

  assign sclBus = sclM & ~sclDriveLow;
  assign sdaBus = sdaM & ~sdaDriveLow;

  tgtByteEngine u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .startStb(startStb), .stopStb(stopStb),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  always @(negedge clk) begin
    if (irq) irqCount++;
    if (rstN && sclBus && prevScl && sdaDriveLow !== prevDrv) sdaHighViol++;
    prevScl = sclBus;
    prevDrv = sdaDriveLow;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic pulseStart();
    @(negedge clk); startStb = 1'b1;
    @(negedge clk); startStb = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopStb = 1'b1;
    @(negedge clk); stopStb = 1'b0;
  endtask

  // one SCL period driven by the bench master; collide issues a status
  // clear in the same cycle that the rising edge is seen
  task automatic clockBit(input logic b, input logic collide, output logic got);
    sdaM = b;
    repeat (3) @(negedge clk);
    sclM = 1'b1;
    if (collide) begin
      wrEn = 1'b1; wrAddr = 3'd2; wrData = 8'h02;
    end
    @(negedge clk);
    wrEn = 1'b0;
    while (!sclBus) @(negedge clk);
    repeat (3) @(negedge clk);
    got = sdaBus;
    sclM = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] got;
    logic       ackGot;
    logic       g;

    repeat (4) @(negedge clk);
    // R12: reset state
    chk("R12 scl released", {31'b0, sclDriveLow}, 0);
    chk("R12 sda released", {31'b0, sdaDriveLow}, 0);
    chk("R12 irq low", {31'b0, irq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      readReg(3'(a), v);
      chk("R12 register zero", {24'b0, v}, 0);
    end

    for (int i = 0; i < NV; i++) begin
      logic [7:0] busExp;
      logic       ackExp;
      logic       errExp;
      busExp = VECS[i].xmit ? (VECS[i].txb & VECS[i].mb) : VECS[i].mb;
      ackExp = VECS[i].xmit ? VECS[i].mAck : (VECS[i].mAck & VECS[i].nack);
      errExp = VECS[i].xmit && ((VECS[i].txb & ~VECS[i].mb) != 8'h00);

      writeReg(3'd3, {6'b0, VECS[i].nack, VECS[i].xmit});
      writeReg(3'd0, VECS[i].txb);
      writeReg(3'd2, 8'h02);
      if (i == 0) begin
        pulseStart();
        sclM = 1'b0;
        repeat (3) @(negedge clk);
      end else begin
        writeReg(3'd4, 8'h01);
        readReg(3'd4, v);
        chk("R6 control reads 0", {24'b0, v}, 0);
      end
      for (int b = 7; b >= 0; b--) begin
        clockBit(VECS[i].mb[b], 1'b0, g);
        got[b] = g;
      end
      clockBit(VECS[i].mAck, 1'b0, ackGot);
      repeat (2) @(negedge clk);

      if (VECS[i].xmit) chk("R1 R7 byte seen on bus", {24'b0, got}, {24'b0, busExp});
      readReg(3'd1, v);
      chk("R2 R7 receive register", {24'b0, v}, {24'b0, busExp});
      readReg(3'd2, v);
      chk("R3 ack status", {31'b0, v[0]}, {31'b0, ackExp});
      chk("R8 error flag", {31'b0, v[1]}, {31'b0, errExp});
      if (!VECS[i].xmit) chk("R9 ack answer on bus", {31'b0, ackGot}, {31'b0, ackExp});
      chk("R5 one irq per byte", irqCount, i + 1);
      chk("R4 scl held in wait", {30'b0, sclDriveLow, sclBus}, 32'h2);
    end

    // R8: set and software clear in the same cycle, set wins
    writeReg(3'd3, 8'h01);
    writeReg(3'd0, 8'hFF);
    writeReg(3'd2, 8'h02);
    writeReg(3'd4, 8'h01);
    clockBit(1'b0, 1'b1, g);
    for (int b = 6; b >= 0; b--) clockBit(1'b1, 1'b0, g);
    clockBit(1'b0, 1'b0, ackGot);
    repeat (2) @(negedge clk);
    readReg(3'd2, v);
    chk("R8 set beats clear", {31'b0, v[1]}, 1);
    readReg(3'd1, v);
    chk("R2 collision byte", {24'b0, v}, 32'h7F);

    // R11: stop during wait
    pulseStop();
    repeat (2) @(negedge clk);
    chk("R11 scl released after stop", {31'b0, sclDriveLow}, 0);
    chk("R11 sda released after stop", {31'b0, sdaDriveLow}, 0);
    chk("R11 no irq from stop", irqCount, NV + 1);
    writeReg(3'd4, 8'h01);
    repeat (2) @(negedge clk);
    chk("R6 release ignored when idle", {31'b0, sclDriveLow}, 0);

    // R8: start strobe clears the error
    sclM = 1'b1;
    repeat (2) @(negedge clk);
    pulseStart();
    readReg(3'd2, v);
    chk("R8 start clears error", {31'b0, v[1]}, 0);

    chk("R10 sda steady while scl high", sdaHighViol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule